// File: doc/BRIEF.md
# Slot-Gated Self-Clocked Serial Word Transmitter

This block sends a 20-bit result word to an external receiver over a serial clock that it makes itself from the master clock. Time is divided into frames of 1024 master clocks. Each frame has sixteen 64-cycle slots: the first eight are reserved for analog settling and carry no serial traffic, and the last eight are digital slots in which a transfer may run.

At the first cycle of every digital slot the block polls an active-low chip select. If the select is low, and a word is held that has not been fully sent, a burst starts in that same cycle. The serial clock has a period of four master clocks and is high for one of them. Bits go out MSB first, change after a falling edge and hold through the rising edge. A burst pauses at the end of a slot or when the select is released (after the current bit), and it resumes with the next bit at a later poll. An active-low ready flag shows when unsent data is held. A fresh word is taken from `word_in` once per frame, after a four-cycle ready-high window at the start of the frame.

Top module: `selfclk_word_tx`

## Requirements
- R1: A frame is 1024 cycles and wraps to 0. `slot_idx` is the frame position divided by 64 and `slot_cyc` is the position modulo 64. Slots 0..7 are analog and slots 8..15 are digital.
- R2: `cs_n` is sampled only in cycle 0 of a digital slot. If it is low there, `sclk_oe` is high in that same cycle. A select that goes low after the poll cycle starts nothing until the next poll.
- R3: Each bit lasts 4 cycles. `sclk_o` is high only in the fourth cycle of each bit, which gives a 25% duty. It is low while `sclk_oe` is low.
- R4: Bits are sent MSB first. `sdata_o` takes a new bit only at a bit boundary, just after the falling edge, and it is stable through the high cycle. `sdata_oe` equals `sclk_oe`.
- R5: If `cs_n` is high in the last cycle of a bit, the burst stops after that bit and both enables drop in the next cycle. The next burst resumes with the following bit.
- R6: A burst stops at the end of a slot. If `cs_n` is low at the next digital poll, it continues there with the next bit.
- R7: After the LSB is sent, the enables drop and `rdy_n` stays high until the next word load. No further burst starts for that word.
- R8: `word_in` is captured at the end of frame cycle 3. `rdy_n` is high in cycles 0..3 of every frame and falls in cycle 4, which restarts the bit order at the MSB. Any unsent bits of the old word are discarded.
- R9: `sclk_oe` is never high in an analog slot.
- R10: During reset `sclk_oe`, `sdata_oe` and `sclk_o` are low, `rdy_n` is high, and the slot outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Active-low select, polled at digital slot starts |
| word_in | input | 20 | Word captured once per frame |
| sclk_o | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Output enable for the serial clock (low = high impedance) |
| sdata_o | output | 1 | Serial data, MSB first |
| sdata_oe | output | 1 | Output enable for the data line |
| rdy_n | output | 1 | Low while an unsent word is held |
| slot_idx | output | 4 | Current slot within the frame |
| slot_cyc | output | 6 | Cycle within the current slot |

## Verification
The bench goes after a word that crosses a slot boundary. A design that lost the bit pointer there would repeat or skip bits after the sixteenth. It also releases the select in the middle of a bit and then re-selects after a missed poll. A wrong design would cut the bit short, or resume at the MSB instead of the next bit. A word left unread across a frame boundary must bring a four-cycle ready-high window and then a fresh MSB-first word. A select that goes low just after the poll cycle must start nothing, which catches a design that samples the select level at any time.

// File: rtl/selfclk_word_tx.sv
module selfclk_word_tx #(
  parameter int WORD_W    = 20,
  parameter int SLOT_LEN  = 64,
  parameter int SLOTS     = 16,
  parameter int ANA_SLOTS = 8,
  parameter int HOLD      = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cs_n,
  input  logic [WORD_W-1:0]           word_in,
  output logic                        sclk_o,
  output logic                        sclk_oe,
  output logic                        sdata_o,
  output logic                        sdata_oe,
  output logic                        rdy_n,
  output logic [$clog2(SLOTS)-1:0]    slot_idx,
  output logic [$clog2(SLOT_LEN)-1:0] slot_cyc
);
  localparam int FRAME = SLOT_LEN * SLOTS;
  localparam int CW    = $clog2(FRAME);
  localparam int OW    = $clog2(SLOT_LEN);
  localparam int SW    = $clog2(SLOTS);
  localparam int PW    = $clog2(WORD_W + 1);

  logic [CW-1:0]     cyc;
  logic [WORD_W-1:0] shreg;
  logic [PW-1:0]     sent;
  logic              have, busy_q;
  logic              digital, poll, done, act, bit_end, stop;

  assign slot_idx = SW'(cyc >> OW);
  assign slot_cyc = cyc[OW-1:0];
  assign digital  = slot_idx >= SW'(ANA_SLOTS);
  assign poll     = digital && (slot_cyc == '0);
  assign done     = sent == PW'(WORD_W);
  assign act      = poll ? (!cs_n && have && !done) : busy_q;
  assign bit_end  = act && (cyc[1:0] == 2'd3);
  assign stop     = cs_n || (sent == PW'(WORD_W - 1)) || (slot_cyc == OW'(SLOT_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc    <= '0;
      shreg  <= '0;
      sent   <= '0;
      have   <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      cyc    <= (cyc == CW'(FRAME - 1)) ? '0 : cyc + 1'b1;
      busy_q <= act && !(bit_end && stop);
      if (cyc == CW'(HOLD - 1)) begin
        shreg <= word_in;
        sent  <= '0;
        have  <= 1'b1;
      end else if (bit_end) begin
        shreg <= shreg << 1;
        sent  <= sent + 1'b1;
      end
    end
  end

  assign sclk_oe  = act;
  assign sdata_oe = act;
  assign sclk_o   = bit_end;
  assign sdata_o  = act && shreg[WORD_W-1];
  assign rdy_n    = !have || done || (cyc < CW'(HOLD));
endmodule

// File: rtl/selfclk_word_tx_chk.sv
module selfclk_word_tx_chk #(
  parameter int SLOT_LEN  = 64,
  parameter int SLOTS     = 16,
  parameter int ANA_SLOTS = 8,
  parameter int HOLD      = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        cs_n,
  input logic                        sclk_o,
  input logic                        sclk_oe,
  input logic                        sdata_o,
  input logic                        sdata_oe,
  input logic                        rdy_n,
  input logic [$clog2(SLOTS)-1:0]    slot_idx,
  input logic [$clog2(SLOT_LEN)-1:0] slot_cyc
);
  AST_START_AT_POLL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_oe) |-> (slot_cyc == '0) && !cs_n); // R2
  AST_CLK_ONE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |=> !sclk_o); // R3
  AST_CLK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> !$past(sclk_o, 2) && !$past(sclk_o, 3)); // R3
  AST_DATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) && $past(sdata_oe) |-> $stable(sdata_o)); // R4
  AST_STOP_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk_oe) |-> $past(sclk_o)); // R5
  AST_RDY_AFTER_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_n) |-> ((slot_idx == '0) && (slot_cyc == '0)) || $past(sclk_o)); // R7
  AST_RDY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_n) |-> (slot_idx == '0) && (slot_cyc == HOLD)); // R8
  AST_DIGITAL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_oe |-> slot_idx >= ANA_SLOTS); // R9
endmodule

bind selfclk_word_tx selfclk_word_tx_chk #(
  .SLOT_LEN(SLOT_LEN), .SLOTS(SLOTS), .ANA_SLOTS(ANA_SLOTS), .HOLD(HOLD)
) u_chk (.*);

// File: tb/sim_selfclk_word_tx.sv
`timescale 1ns/1ps
module sim_selfclk_word_tx;
  logic clk = 1'b0, rst_n = 1'b0, cs_n = 1'b1;
  logic [19:0] word_in = '0;
  logic sclk_o, sclk_oe, sdata_o, sdata_oe, rdy_n;
  logic [3:0] slot_idx;
  logic [5:0] slot_cyc;

  selfclk_word_tx u0 (.clk, .rst_n, .cs_n, .word_in, .sclk_o, .sclk_oe,
    .sdata_o, .sdata_oe, .rdy_n, .slot_idx, .slot_cyc);

  always #2 clk = ~clk;

  int checks = 0, fails = 0, bcnt = 0, rx_cnt = 0, bad_ana = 0, bad_slot = 0;
  logic [19:0] rx = '0;
  bit finished = 0;

  always @(posedge clk) if (!rst_n) bcnt <= 0; else bcnt <= bcnt + 1;

  always @(negedge clk) if (rst_n) begin
    if (sclk_oe && sclk_o) begin rx = {rx[18:0], sdata_o}; rx_cnt++; end
    if (sclk_oe && ((bcnt % 1024) / 64) < 8) bad_ana++;
    if (slot_idx != 4'((bcnt % 1024) / 64) || slot_cyc != 6'(bcnt % 64)) bad_slot++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (!ok) begin fails++; $display("FAIL %s: actual %0h expected %0h", req, a, e); end
  endtask

  task automatic wait_to(input int p);
    do @(negedge clk); while ((bcnt % 1024) != p);
    #1;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk(!sclk_oe && !sdata_oe && !sclk_o, "R10", {sclk_oe, sdata_oe, sclk_o}, 0);
    chk(rdy_n == 1'b1, "R10", rdy_n, 1);
    chk(slot_idx == 0 && slot_cyc == 0, "R10", {slot_idx, slot_cyc}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_read_full(input logic [19:0] w);
    int base;
    wait_to(1000); word_in = w; cs_n = 1'b1;
    wait_to(10); base = rx_cnt; cs_n = 1'b0;
    wait_to(511); chk(!sclk_oe, "R9", sclk_oe, 0);
    wait_to(512);
    chk(sclk_oe && sdata_oe && !sclk_o, "R2", {sclk_oe, sdata_oe, sclk_o}, 3'b110);
    chk(sdata_o == w[19], "R4", sdata_o, w[19]);
    wait_to(514); chk(sclk_o == 1'b0, "R3", sclk_o, 0);
    wait_to(515); chk(sclk_o == 1'b1, "R3", sclk_o, 1);
    wait_to(576); chk(sclk_oe && sdata_o == w[3], "R6", {sclk_oe, sdata_o}, {1'b1, w[3]});
    wait_to(592);
    chk(!sclk_oe && rdy_n, "R7", {sclk_oe, rdy_n}, 2'b01);
    chk(rx_cnt - base == 20 && rx == w, "R4", rx, w);
    wait_to(650); chk(!sclk_oe, "R7", sclk_oe, 0);
    wait_to(1023); chk(rdy_n == 1'b1, "R7", rdy_n, 1);
    wait_to(2); chk(rdy_n == 1'b1, "R8", rdy_n, 1);
    wait_to(4); chk(rdy_n == 1'b0, "R8", rdy_n, 0);
    cs_n = 1'b1;
  endtask

  task automatic t_abort_resume(input logic [19:0] w);
    int base;
    wait_to(1000); word_in = w; cs_n = 1'b1;
    wait_to(10); base = rx_cnt; cs_n = 1'b0;
    wait_to(521); cs_n = 1'b1;
    wait_to(523); chk(sclk_oe && sclk_o, "R5", {sclk_oe, sclk_o}, 2'b11);
    wait_to(524);
    chk(!sclk_oe && !sdata_oe, "R5", {sclk_oe, sdata_oe}, 0);
    chk(rx_cnt - base == 3, "R5", rx_cnt - base, 3);
    wait_to(600); chk(rx_cnt - base == 3, "R2", rx_cnt - base, 3); cs_n = 1'b0;
    wait_to(640); chk(sclk_oe && sdata_o == w[16], "R5", {sclk_oe, sdata_o}, {1'b1, w[16]});
    wait_to(710);
    chk(rx_cnt - base == 20 && rx == w, "R5", rx, w);
    chk(rdy_n == 1'b1, "R7", rdy_n, 1);
    cs_n = 1'b1;
  endtask

  task automatic t_unread_roll(input logic [19:0] w1, input logic [19:0] w2);
    int base;
    wait_to(1000); word_in = w1; cs_n = 1'b1;
    wait_to(1000); chk(rdy_n == 1'b0, "R8", rdy_n, 0); word_in = w2;
    wait_to(0); chk(rdy_n == 1'b1, "R8", rdy_n, 1);
    wait_to(3); chk(rdy_n == 1'b1, "R8", rdy_n, 1);
    wait_to(4); chk(rdy_n == 1'b0, "R8", rdy_n, 0);
    wait_to(10); base = rx_cnt; cs_n = 1'b0;
    wait_to(600); chk(rx_cnt - base == 20 && rx == w2, "R8", rx, w2);
    cs_n = 1'b1;
  endtask

  task automatic t_partial_reload(input logic [19:0] w1, input logic [19:0] w2);
    int base;
    wait_to(1000); word_in = w1; cs_n = 1'b1;
    wait_to(10); base = rx_cnt; cs_n = 1'b0;
    wait_to(530); cs_n = 1'b1;
    wait_to(540); chk(rx_cnt - base == 5 && !sclk_oe, "R5", rx_cnt - base, 5);
    wait_to(1000); word_in = w2;
    wait_to(10); base = rx_cnt; cs_n = 1'b0;
    wait_to(512); chk(sdata_o == w2[19], "R8", sdata_o, w2[19]);
    wait_to(600); chk(rx_cnt - base == 20 && rx == w2, "R8", rx, w2);
    cs_n = 1'b1;
  endtask

  task automatic t_late_select(input logic [19:0] w);
    int base;
    wait_to(1000); word_in = w; cs_n = 1'b1;
    wait_to(10); base = rx_cnt;
    wait_to(520); cs_n = 1'b0;
    wait_to(560); chk(!sclk_oe && rx_cnt == base, "R2", sclk_oe, 0);
    wait_to(577); chk(sclk_oe == 1'b1, "R2", sclk_oe, 1);
    wait_to(700); chk(rx_cnt - base == 20 && rx == w, "R6", rx, w);
    cs_n = 1'b1;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
          checks++; fails++;
          $display("FAIL watchdog: actual timeout expected completion");
          $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
          $finish;
        end
      end
    join_none
    t_reset();
    t_read_full(20'hA5C3E);
    t_abort_resume(20'h3F0C1);
    t_unread_roll(20'h12345, 20'hFEDCB);
    t_partial_reload(20'h0F0F0, 20'h80001);
    t_late_select(20'h5A5A5);
    t_read_full(20'h00001);
    chk(bad_ana == 0, "R9", bad_ana, 0);
    chk(bad_slot == 0, "R1", bad_slot, 0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule